// File: doc/BRIEF.md
# I2C Slave Address Recognizer with General Call

This block sits behind the bit-level front end of an I2C target. The front end supplies one-cycle event pulses: a START (or repeated START) seen, a STOP seen, and each received data bit together with its value. The recognizer assembles the first byte after each START, most significant bit first. It compares the upper seven bits with the node's own address and, when enabled, compares the whole byte with the general call address. The result goes to the control logic as two separate match flags plus the received direction bit.

The own address and the general call enable share one configuration word. `addr_cfg_i[7:1]` holds the address and `addr_cfg_i[0]` enables general call recognition. A separate `ack_en_i` input decides whether a matched address is acknowledged. When acknowledged, `ack_drive_o` tells the pad logic to pull SDA low for the acknowledge slot. Otherwise SDA stays released, which is a NACK. Every match also produces a one-cycle wake request, so a sleeping host can be woken by the comparison alone.

The control is a four-state machine:

- ST_IDLE waits for a START.
- ST_ADDR shifts in the address byte.
- ST_ACK covers the acknowledge slot after a match.
- ST_SKIP ignores the rest of the transfer.

Transitions:

- A START moves any state to ST_ADDR. It has priority over everything else.
- A STOP moves any state to ST_IDLE.
- ST_ADDR moves to ST_ACK on the eighth bit if either comparison hits, and to ST_SKIP if neither does.
- ST_ACK moves to ST_SKIP on the ninth bit, which is the acknowledge slot.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `own_hit_o`, `gcall_hit_o`, `rw_o`, `ack_drive_o` and `wake_o` are all 0.
- R2: The first bit received after a START is bit 7 of the address byte. If byte bits 7..1 equal `addr_cfg_i[7:1]`, `own_hit_o` is 1 from the cycle after the eighth bit's pulse until the next START or STOP.
- R3: In the cycle after the eighth bit, `rw_o` takes the eighth bit (byte bit 0) of every address byte. It holds that value until the next START or STOP.
- R4: When `addr_cfg_i[0]` is 1 and the address byte is 8'h00, `gcall_hit_o` is 1 in the cycle after the eighth bit. When `addr_cfg_i[0]` is 0, byte 8'h00 raises no general call match.
- R5: Address byte 8'h01 (zero address with R/W = 1) never raises `gcall_hit_o`.
- R6: `ack_drive_o` is 1 from the cycle after the eighth bit until the ninth bit's pulse. This happens only when a match occurred and `ack_en_i` was 1 in the eighth bit's cycle; otherwise `ack_drive_o` stays 0.
- R7: On every match, `wake_o` is a single-cycle pulse in the cycle after the eighth bit.
- R8: Bytes after the first in the same transfer never change the match flags, never drive the acknowledge and never raise a wake pulse.
- R9: A repeated START clears the match flags, `rw_o` and `ack_drive_o`, and restarts comparison on the next byte. A STOP clears them and returns the block to idle.
- R10: Bits that arrive while idle, with no START before them, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_det_i | input | 1 | One-cycle pulse: START or repeated START seen |
| stop_det_i | input | 1 | One-cycle pulse: STOP seen |
| bit_vld_i | input | 1 | One-cycle pulse: a bus bit was sampled |
| bit_dat_i | input | 1 | Value of the sampled bit |
| addr_cfg_i | input | ADDR_W+1 | Bits ADDR_W..1: own address; bit 0: general call enable |
| ack_en_i | input | 1 | Allow acknowledge of a matched address |
| own_hit_o | output | 1 | Own address matched |
| gcall_hit_o | output | 1 | General call matched |
| rw_o | output | 1 | Received direction bit |
| ack_drive_o | output | 1 | Pull SDA low for the acknowledge slot |
| wake_o | output | 1 | Wake request pulse on a match |

## Verification
The bench builds the block with its default `ADDR_W` of 7, which matches the real bus byte. This puts the general call byte 8'h00, its read-direction variant 8'h01, and full 7-bit addresses with both direction bits within reach. It also lets the configuration word switch between an own address whose low bit is set and one whose low bit is clear, and between general call enabled and disabled. This shows that only bit 0 of the configuration acts as the enable and that it never takes part in the address compare.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_ACK  = 2'd2,
        ST_SKIP = 2'd3
    } am_state_e;
endpackage

// File: rtl/am_addr_shift.sv
module am_addr_shift #(
    parameter int ADDR_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            shift_en_i,
    input  logic            bit_vld_i,
    input  logic            bit_dat_i,
    output logic [ADDR_W:0] byte_o,
    output logic            last_o
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    logic [ADDR_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (clear_i) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (shift_en_i && bit_vld_i) begin
            shreg_q <= {shreg_q[ADDR_W-2:0], bit_dat_i};
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Full byte including the bit arriving this cycle
    assign byte_o = {shreg_q, bit_dat_i};
    assign last_o = shift_en_i && bit_vld_i && (cnt_q == CNT_W'(ADDR_W));
endmodule

// File: rtl/am_addr_cmp.sv
module am_addr_cmp #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W:0] byte_i,
    input  logic [ADDR_W:0] cfg_i,
    output logic            own_o,
    output logic            gc_o
);
    localparam logic [ADDR_W:0] GC_BYTE = '0;

    always_comb begin
        own_o = (byte_i[ADDR_W:1] == cfg_i[ADDR_W:1]);
        gc_o  = cfg_i[0] && (byte_i == GC_BYTE);
    end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_det_i,
    input  logic            stop_det_i,
    input  logic            bit_vld_i,
    input  logic            bit_dat_i,
    input  logic [ADDR_W:0] addr_cfg_i,
    input  logic            ack_en_i,
    output logic            own_hit_o,
    output logic            gcall_hit_o,
    output logic            rw_o,
    output logic            ack_drive_o,
    output logic            wake_o
);
    am_state_e       state_q, state_d;
    logic [ADDR_W:0] byte_w;
    logic            last_w, own_w, gc_w, any_w;

    am_addr_shift #(.ADDR_W(ADDR_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_det_i),
        .shift_en_i (state_q == ST_ADDR),
        .bit_vld_i  (bit_vld_i),
        .bit_dat_i  (bit_dat_i),
        .byte_o     (byte_w),
        .last_o     (last_w)
    );

    am_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .byte_i (byte_w),
        .cfg_i  (addr_cfg_i),
        .own_o  (own_w),
        .gc_o   (gc_w)
    );

    assign any_w = own_w || gc_w;

    // Next state: START wins, then STOP, then per-state progress
    always_comb begin
        state_d = state_q;
        if (start_det_i) begin
            state_d = ST_ADDR;
        end else if (stop_det_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ADDR: if (last_w) state_d = any_w ? ST_ACK : ST_SKIP;
                ST_ACK:  if (bit_vld_i) state_d = ST_SKIP;
                ST_SKIP: state_d = ST_SKIP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_hit_o   <= 1'b0;
            gcall_hit_o <= 1'b0;
            rw_o        <= 1'b0;
            ack_drive_o <= 1'b0;
            wake_o      <= 1'b0;
        end else begin
            wake_o <= 1'b0;
            if (start_det_i || stop_det_i) begin
                own_hit_o   <= 1'b0;
                gcall_hit_o <= 1'b0;
                rw_o        <= 1'b0;
                ack_drive_o <= 1'b0;
            end else if (last_w) begin
                own_hit_o   <= own_w;
                gcall_hit_o <= gc_w;
                rw_o        <= byte_w[0];
                ack_drive_o <= any_w && ack_en_i;
                wake_o      <= any_w;
            end else if (state_q == ST_ACK && bit_vld_i) begin
                ack_drive_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk #(
    parameter int ADDR_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_det_i,
    input logic [ADDR_W:0] addr_cfg_i,
    input logic            ack_en_i,
    input logic            own_hit_o,
    input logic            gcall_hit_o,
    input logic            rw_o,
    input logic            ack_drive_o,
    input logic            wake_o
);
    AST_ACK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ack_drive_o |-> (own_hit_o || gcall_hit_o)); // R6
    AST_ACK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_drive_o) |-> $past(ack_en_i)); // R6
    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o); // R7
    AST_WAKE_HAS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (own_hit_o || gcall_hit_o)); // R7
    AST_GC_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gcall_hit_o) |-> $past(addr_cfg_i[0])); // R4
    AST_GC_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        gcall_hit_o |-> !rw_o); // R5
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_det_i |=> (!own_hit_o && !gcall_hit_o && !ack_drive_o && !rw_o)); // R9
endmodule

bind i2c_addr_match i2c_addr_match_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_det_i (start_det_i),
    .addr_cfg_i  (addr_cfg_i),
    .ack_en_i    (ack_en_i),
    .own_hit_o   (own_hit_o),
    .gcall_hit_o (gcall_hit_o),
    .rw_o        (rw_o),
    .ack_drive_o (ack_drive_o),
    .wake_o      (wake_o)
);

// File: tb/i2c_addr_match_test.sv
module i2c_addr_match_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_det_i = 1'b0, stop_det_i = 1'b0;
    logic       bit_vld_i = 1'b0, bit_dat_i = 1'b0;
    logic [7:0] addr_cfg_i = 8'h00;
    logic       ack_en_i = 1'b0;
    logic       own_hit_o, gcall_hit_o, rw_o, ack_drive_o, wake_o;
    int         n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    i2c_addr_match #(.ADDR_W(7)) uut (.*);

    // cfg[19:12] ack[11] byte[10:3] own[2] gc[1] ack_exp[0]
    localparam int NV = 8;
    localparam logic [19:0] VEC [NV] = '{
        {8'hA0, 1'b1, 8'hA0, 1'b1, 1'b0, 1'b1},
        {8'hA0, 1'b1, 8'hA1, 1'b1, 1'b0, 1'b1},
        {8'hA0, 1'b0, 8'hA0, 1'b1, 1'b0, 1'b0},
        {8'hA1, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1},
        {8'hA0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0},
        {8'hA1, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0},
        {8'h3D, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b1},
        {8'hA0, 1'b1, 8'hA2, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_det_i = 1'b1;
        @(negedge clk) start_det_i = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_det_i = 1'b1;
        @(negedge clk) stop_det_i = 1'b0;
    endtask

    // Ends at the negedge right after the edge that consumed the bit
    task automatic send_bit(input logic b);
        @(negedge clk) begin bit_vld_i = 1'b1; bit_dat_i = b; end
        @(negedge clk) bit_vld_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(own_hit_o, 1'b0, "R1 own");
        check(gcall_hit_o, 1'b0, "R1 gc");
        check(rw_o, 1'b0, "R1 rw");
        check(ack_drive_o, 1'b0, "R1 ack");
        check(wake_o, 1'b0, "R1 wake");

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int k = 0; k < NV; k++) begin
            addr_cfg_i = VEC[k][19:12];
            ack_en_i   = VEC[k][11];
            pulse_start();
            send_byte(VEC[k][10:3]);
            check(own_hit_o, VEC[k][2], "R2 own match");
            check(gcall_hit_o, VEC[k][1], "R4/R5 general call");
            check(rw_o, VEC[k][3], "R3 direction bit");
            check(ack_drive_o, VEC[k][0], "R6 ack drive");
            check(wake_o, VEC[k][2] | VEC[k][1], "R7 wake pulse");
            @(negedge clk);
            check(wake_o, 1'b0, "R7 wake single cycle");
            send_bit(1'b0);
            check(ack_drive_o, 1'b0, "R6 ack released after slot");
            check(own_hit_o, VEC[k][2], "R2 own held");
            pulse_stop();
        end

        // R8: matching second byte in the same transfer
        addr_cfg_i = 8'hA1; ack_en_i = 1'b1;
        pulse_start();
        send_byte(8'h44);
        check(own_hit_o, 1'b0, "R8 first byte miss");
        send_bit(1'b1);
        send_byte(8'hA0);
        check(own_hit_o, 1'b0, "R8 later byte own");
        check(wake_o, 1'b0, "R8 later byte wake");
        check(ack_drive_o, 1'b0, "R8 later byte ack");
        send_bit(1'b1);
        send_byte(8'h00);
        check(gcall_hit_o, 1'b0, "R8 later byte gc");

        // R9: repeated START clears and re-compares
        pulse_start();
        check(own_hit_o, 1'b0, "R9 restart clears own");
        send_byte(8'hA1);
        check(own_hit_o, 1'b1, "R9 restart compares");
        check(rw_o, 1'b1, "R9 rw after restart");
        pulse_start();
        check(own_hit_o, 1'b0, "R9 repeated start clears own");
        check(ack_drive_o, 1'b0, "R9 repeated start clears ack");
        check(rw_o, 1'b0, "R9 repeated start clears rw");
        send_byte(8'h00);
        check(gcall_hit_o, 1'b1, "R9 gc after restart");
        pulse_stop();
        check(gcall_hit_o, 1'b0, "R9 stop clears gc");
        check(ack_drive_o, 1'b0, "R9 stop clears ack");

        // R10: bits without a START
        send_byte(8'hA0);
        check(own_hit_o, 1'b0, "R10 idle own");
        check(wake_o, 1'b0, "R10 idle wake");
        check(ack_drive_o, 1'b0, "R10 idle ack");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule